// File: doc/BRIEF.md
# USB device reset and chirp sequencer

This block is the bus-reset front end of a USB device controller. It watches the two-bit line state reported by the transceiver macrocell and first filters out short glitches. It then times how long single-ended zero (SE0) persists. Once SE0 has lasted long enough to count as a host reset, the block raises `usb_reset` and, in the same cycle, drives a device Chirp-K with the transceiver in high-speed mode and full-speed termination.

When the Chirp-K ends, the block listens for the host's answering K/J chirp for a bounded window. If the host chirps, the block records a high-speed-capable host and leaves reset early. If the host does not chirp, the block falls back to full-speed settings. In both cases it waits for the line to return to idle J before it arms itself for the next reset.

Every duration is a parameter counted in clock cycles. The defaults are derived from a clock-frequency parameter, so a test setup can shrink them. All pins are plain control and status levels; nothing here streams data, so no valid/ready handshake is involved.

Top module: `usb_reset_sequencer`

## Requirements
- R1: In synchronous reset, and afterwards until a bus reset is recognised, the outputs are `usb_reset`=0, `xcvr_select`=1, `term_select`=1, `opmode`=00, `chirp_drive`=0 and `hs_mode`=0.
- R2: The line state is encoded as 00 = SE0, 01 = J, 10 = K, 11 = SE1. A change on the line is acted on only after it has held for DEB_CYC consecutive cycles. Shorter pulses, including an endless train of one-cycle SE0 pulses, never start reset timing.
- R3: If filtered SE0 ends (to J, K or SE1) before RECOG_CYC cycles, the block returns to idle without asserting `usb_reset`. The elapsed count is discarded, so two short SE0 periods never add up.
- R4: After RECOG_CYC cycles of continuous filtered SE0, `usb_reset` and `chirp_drive` rise in the same cycle and `hs_mode` is cleared.
- R5: While `chirp_drive` is high, `xcvr_select`=0, `term_select`=1 and `opmode`=10. The Chirp-K lasts exactly CHIRP_CYC cycles whatever the line does meanwhile.
- R6: After the Chirp-K, the host-wait window follows for at most WAIT_CYC cycles, with `usb_reset`=1, `chirp_drive`=0, `xcvr_select`=0, `term_select`=1 and `opmode`=00.
- R7: If the window expires without a host chirp, `usb_reset` falls and the full-speed settings apply: `xcvr_select`=1, `term_select`=1, `opmode`=00, `hs_mode`=0.
- R8: A host chirp is SEG_COUNT alternating K/J segments. The first segment is K, and each segment holds longer than SEG_MIN_CYC cycles. A chirp seen inside the window ends the wait at once: `usb_reset`=0, `hs_mode`=1, `xcvr_select`=0, `term_select`=0, `opmode`=00.
- R9: Any of the following prevents high-speed detection and leads to the full-speed fallback: a pattern that starts with J, a pattern with fewer than SEG_COUNT alternations, or a segment shorter than SEG_MIN_CYC.
- R10: After either ending, the settings hold while SE0 continues. They return to idle only once filtered J is seen. `hs_mode` keeps its value until the next recognised reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_state | input | 2 | Line state from the transceiver (00 SE0, 01 J, 10 K, 11 SE1) |
| usb_reset | output | 1 | High while the host reset is being handled |
| xcvr_select | output | 1 | Transceiver select: 0 high-speed, 1 full-speed |
| term_select | output | 1 | Termination select: 0 high-speed, 1 full-speed |
| opmode | output | 2 | Operating mode: 00 normal, 10 chirp drive |
| chirp_drive | output | 1 | Requests the device Chirp-K on the line |
| hs_mode | output | 1 | 1 when a host chirp was detected, 0 for full-speed |

## Verification
The hardest situation to reach is a host chirp that lands entirely inside the wait window. Its segments must sit near the minimum-length threshold, and the pattern must start only after the Chirp-K has ended. The stimulus watches `chirp_drive` fall at the ports and times its K/J segments from that edge. It adds random jitter to segment lengths and mixes in the broken patterns (starting with J, too few segments, one short segment), so the detector sees both outcomes close to its boundaries. Randomised line noise during the Chirp-K also shows that the chirp length does not depend on the line.

// File: rtl/usbrst_pkg.sv
package usbrst_pkg;

  // Line state encoding as delivered by the transceiver
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SE0_TIME,
    ST_CHIRP,
    ST_HOST_WAIT,
    ST_FS_DONE,
    ST_HS_DONE
  } seq_t;

  localparam logic [1:0] OPM_NORMAL = 2'b00;
  localparam logic [1:0] OPM_CHIRP  = 2'b10;

  typedef struct packed {
    logic       in_reset;
    logic       xcvr;
    logic       term;
    logic [1:0] opmode;
    logic       chirp;
  } phy_ctl_t;

endpackage

// File: rtl/usbrst_line_filter.sv
module usbrst_line_filter
  import usbrst_pkg::*;
#(
  parameter int DEB_CYC = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  raw,
  output line_t       filt
);

  generate
    if (DEB_CYC == 0) begin : g_bypass
      line_t filt_q;
      always_ff @(posedge clk) begin
        if (rst) filt_q <= LS_J;
        else     filt_q <= line_t'(raw);
      end
      assign filt = filt_q;
    end else begin : g_debounce
      localparam int SW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
      logic [1:0]    sync_q;
      line_t         cand_q;
      line_t         filt_q;
      logic [SW-1:0] stab_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q <= LS_J;
          cand_q <= LS_J;
          filt_q <= LS_J;
          stab_q <= '0;
        end else begin
          sync_q <= raw;
          if (line_t'(sync_q) != cand_q) begin
            cand_q <= line_t'(sync_q);
            stab_q <= '0;
          end else if (stab_q == SW'(DEB_CYC - 1)) begin
            filt_q <= cand_q;
          end else begin
            stab_q <= stab_q + 1'b1;
          end
        end
      end
      assign filt = filt_q;
    end
  endgenerate

endmodule

// File: rtl/usbrst_host_chirp.sv
module usbrst_host_chirp
  import usbrst_pkg::*;
#(
  parameter int SEG_MIN_CYC = 150,
  parameter int SEG_COUNT   = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  line_t ls,
  output logic  found
);

  localparam int RW = $clog2(SEG_MIN_CYC + 1);
  localparam int CW = $clog2(SEG_COUNT + 1);

  line_t         prev_q;
  line_t         last_q;
  logic [RW-1:0] run_q;
  logic [CW-1:0] cnt_q;
  logic          qualify;

  // A run qualifies on the cycle its length reaches the minimum
  assign qualify = (ls == prev_q) && (run_q == RW'(SEG_MIN_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      prev_q <= ls;
      last_q <= LS_SE0;
      run_q  <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= ls;
      if (ls != prev_q) begin
        run_q <= '0;
        if (run_q < RW'(SEG_MIN_CYC)) cnt_q <= '0;
      end else if (run_q != RW'(SEG_MIN_CYC)) begin
        run_q <= run_q + 1'b1;
      end

      if (qualify) begin
        last_q <= ls;
        case (ls)
          LS_K: begin
            if (cnt_q != '0 && last_q == LS_J && cnt_q != CW'(SEG_COUNT))
              cnt_q <= cnt_q + 1'b1;
            else
              cnt_q <= CW'(1);
          end
          LS_J: begin
            if (cnt_q != '0 && last_q == LS_K && cnt_q != CW'(SEG_COUNT))
              cnt_q <= cnt_q + 1'b1;
            else
              cnt_q <= '0;
          end
          default: cnt_q <= '0;
        endcase
      end
    end
  end

  assign found = en && (cnt_q == CW'(SEG_COUNT));

endmodule

// File: rtl/usbrst_phy_map.sv
module usbrst_phy_map
  import usbrst_pkg::*;
(
  input  seq_t     st,
  output phy_ctl_t ctl
);

  always_comb begin
    ctl = '{in_reset: 1'b0, xcvr: 1'b1, term: 1'b1, opmode: OPM_NORMAL, chirp: 1'b0};
    case (st)
      ST_CHIRP: begin
        ctl.in_reset = 1'b1;
        ctl.xcvr     = 1'b0;
        ctl.opmode   = OPM_CHIRP;
        ctl.chirp    = 1'b1;
      end
      ST_HOST_WAIT: begin
        ctl.in_reset = 1'b1;
        ctl.xcvr     = 1'b0;
      end
      ST_HS_DONE: begin
        ctl.xcvr = 1'b0;
        ctl.term = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/usb_reset_sequencer.sv
module usb_reset_sequencer
  import usbrst_pkg::*;
#(
  parameter int CLK_HZ      = 60_000_000,
  parameter int DEB_CYC     = 4,
  parameter int RECOG_CYC   = (CLK_HZ / 1000) * 68 / 1000,
  parameter int CHIRP_CYC   = (CLK_HZ / 1000) * 3 / 2,
  parameter int WAIT_CYC    = (CLK_HZ / 1000) * 2,
  parameter int SEG_MIN_CYC = (CLK_HZ / 1000) * 5 / 2000,
  parameter int SEG_COUNT   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_state,
  output logic       usb_reset,
  output logic       xcvr_select,
  output logic       term_select,
  output logic [1:0] opmode,
  output logic       chirp_drive,
  output logic       hs_mode
);

  localparam int MAXC = (RECOG_CYC > CHIRP_CYC)
                      ? ((RECOG_CYC > WAIT_CYC) ? RECOG_CYC : WAIT_CYC)
                      : ((CHIRP_CYC > WAIT_CYC) ? CHIRP_CYC : WAIT_CYC);
  localparam int TW   = $clog2(MAXC + 1);

  line_t         ls_f;
  seq_t          st_q;
  logic [TW-1:0] tmr_q;
  logic          hs_q;
  logic          host_found;
  phy_ctl_t      ctl;

  usbrst_line_filter #(.DEB_CYC(DEB_CYC)) u_filter (
    .clk  (clk),
    .rst  (rst),
    .raw  (line_state),
    .filt (ls_f)
  );

  usbrst_host_chirp #(.SEG_MIN_CYC(SEG_MIN_CYC), .SEG_COUNT(SEG_COUNT)) u_hchirp (
    .clk   (clk),
    .rst   (rst),
    .en    (st_q == ST_HOST_WAIT),
    .ls    (ls_f),
    .found (host_found)
  );

  // One phase timer shared by all timed states, cleared on each change
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
      hs_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          tmr_q <= '0;
          if (ls_f == LS_SE0) st_q <= ST_SE0_TIME;
        end
        ST_SE0_TIME: begin
          if (ls_f != LS_SE0) begin
            st_q  <= ST_IDLE;
            tmr_q <= '0;
          end else if (tmr_q == TW'(RECOG_CYC - 1)) begin
            st_q  <= ST_CHIRP;
            tmr_q <= '0;
            hs_q  <= 1'b0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_CHIRP: begin
          if (tmr_q == TW'(CHIRP_CYC - 1)) begin
            st_q  <= ST_HOST_WAIT;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_HOST_WAIT: begin
          if (host_found) begin
            st_q  <= ST_HS_DONE;
            tmr_q <= '0;
            hs_q  <= 1'b1;
          end else if (tmr_q == TW'(WAIT_CYC - 1)) begin
            st_q  <= ST_FS_DONE;
            tmr_q <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_FS_DONE, ST_HS_DONE: begin
          tmr_q <= '0;
          if (ls_f == LS_J) st_q <= ST_IDLE;
        end
        default: begin
          st_q  <= ST_IDLE;
          tmr_q <= '0;
        end
      endcase
    end
  end

  usbrst_phy_map u_map (
    .st  (st_q),
    .ctl (ctl)
  );

  assign usb_reset   = ctl.in_reset;
  assign xcvr_select = ctl.xcvr;
  assign term_select = ctl.term;
  assign opmode      = ctl.opmode;
  assign chirp_drive = ctl.chirp;
  assign hs_mode     = hs_q;

endmodule

// File: rtl/usbrst_seq_chk.sv
module usbrst_seq_chk #(
  parameter int CHIRP_CYC = 90000,
  parameter int WAIT_CYC  = 120000
) (
  input logic       clk,
  input logic       rst,
  input logic       usb_reset,
  input logic       xcvr_select,
  input logic       term_select,
  input logic [1:0] opmode,
  input logic       chirp_drive,
  input logic       hs_mode
);

  int unsigned chirp_len;
  int unsigned wait_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      chirp_len <= 0;
      wait_len  <= 0;
    end else begin
      chirp_len <= chirp_drive ? chirp_len + 1 : 0;
      wait_len  <= (usb_reset && !chirp_drive) ? wait_len + 1 : 0;
    end
  end

  // R4: reset recognition starts the chirp in the same cycle and clears the status
  p_rise_chirp_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(usb_reset) |-> chirp_drive && !hs_mode);

  // R5: chirp settings
  p_chirp_cfg_r5: assert property (@(posedge clk) disable iff (rst)
    chirp_drive |-> (usb_reset && !xcvr_select && term_select && opmode == 2'b10));

  // R5: chirp length is exact
  p_chirp_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(chirp_drive) |-> chirp_len == CHIRP_CYC);

  // R6: host-wait window never overruns
  p_wait_len_r6: assert property (@(posedge clk) disable iff (rst)
    (usb_reset && !chirp_drive) |-> (wait_len < WAIT_CYC && opmode == 2'b00 && !xcvr_select));

  // R7 / R8: settings on leaving reset match the outcome
  p_fall_cfg_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(usb_reset) |-> (opmode == 2'b00 &&
      (hs_mode ? (!xcvr_select && !term_select) : (xcvr_select && term_select))));

  // R8: the status is set only at the end of the wait
  p_hs_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_mode) |-> $fell(usb_reset));

endmodule

bind usb_reset_sequencer usbrst_seq_chk #(
  .CHIRP_CYC (CHIRP_CYC),
  .WAIT_CYC  (WAIT_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .usb_reset   (usb_reset),
  .xcvr_select (xcvr_select),
  .term_select (term_select),
  .opmode      (opmode),
  .chirp_drive (chirp_drive),
  .hs_mode     (hs_mode)
);

// File: tb/usb_reset_sequencer_tb.sv
module usb_reset_sequencer_tb;

  localparam int DEB   = 2;
  localparam int RECOG = 40;
  localparam int CHIRP = 60;
  localparam int WAITC = 120;
  localparam int SEGM  = 8;
  localparam int SEGN  = 3;

  localparam logic [1:0] SE0 = 2'b00, LJ = 2'b01, LK = 2'b10, SE1 = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] line = LJ;
  logic       usb_reset, xcvr_select, term_select, chirp_drive, hs_mode;
  logic [1:0] opmode;

  always #10 clk = ~clk;

  usb_reset_sequencer #(
    .CLK_HZ(50_000_000), .DEB_CYC(DEB), .RECOG_CYC(RECOG), .CHIRP_CYC(CHIRP),
    .WAIT_CYC(WAITC), .SEG_MIN_CYC(SEGM), .SEG_COUNT(SEGN)
  ) u_dut (
    .clk(clk), .rst(rst), .line_state(line), .usb_reset(usb_reset),
    .xcvr_select(xcvr_select), .term_select(term_select), .opmode(opmode),
    .chirp_drive(chirp_drive), .hs_mode(hs_mode)
  );

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic exp_hs = 1'b0;

  // phase: 0 idle/full-speed, 1 chirp, 2 host wait, 3 high-speed end
  function automatic logic [6:0] exp_vec(int phase, logic hs);
    case (phase)
      1:       return {1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0};
      2:       return {1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0};
      3:       return {1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1};
      default: return {1'b0, 1'b1, 1'b1, 2'b00, 1'b0, hs};
    endcase
  endfunction

  function automatic logic [6:0] obs();
    return {usb_reset, xcvr_select, term_select, opmode, chirp_drive, hs_mode};
  endfunction

  // expected outcome of a chirp pattern kind: 1 only is a valid host chirp
  function automatic bit pattern_is_hs(int kind);
    return kind == 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic seg(logic [1:0] v, int n, inout int t);
    line = v;
    cyc(n);
    t += n;
  endtask

  // One full bus reset; kind: 0 none, 1 K-J-K, 2 K-J, 3 J-K-J, 4 K-shortJ-K
  task automatic bus_reset(int kind, int jit);
    int n;
    int len;
    int t;
    int sl;
    sl = SEGM + 6 + jit;
    line = SE0;
    cyc(RECOG - 6);
    chk("R3 no reset before threshold", obs(), exp_vec(0, exp_hs));
    n = RECOG - 6;
    while (!chirp_drive && n < RECOG + 50) begin
      cyc(1);
      n++;
    end
    chk("R4 recognition latency", (n >= RECOG && n <= RECOG + DEB + 6), 1);
    chk("R4 R5 chirp settings", obs(), exp_vec(1, 1'b0));
    exp_hs = 1'b0;
    len = 1;
    while (1) begin
      line = 2'($urandom);
      cyc(1);
      if (chirp_drive) len++;
      else break;
      if (len > CHIRP + 10) break;
    end
    chk("R5 chirp length with line noise", len, CHIRP);
    chk("R6 wait settings", obs(), exp_vec(2, 1'b0));
    t = 0;
    seg(SE0, 6, t);
    case (kind)
      1: begin seg(LK, sl, t); seg(LJ, sl, t); seg(LK, sl, t); end
      2: begin seg(LK, sl, t); seg(LJ, sl, t); end
      3: begin seg(LJ, sl, t); seg(LK, sl, t); seg(LJ, sl, t); end
      4: begin seg(LK, sl, t); seg(LJ, SEGM - 4, t); seg(LK, sl, t); end
      default: ;
    endcase
    line = SE0;
    if (pattern_is_hs(kind)) begin
      cyc(75 - t);
      chk("R8 host chirp detected", obs(), exp_vec(3, 1'b1));
      exp_hs = 1'b1;
    end else begin
      cyc(100 - t);
      chk("R6 still waiting", obs(), exp_vec(2, 1'b0));
      cyc(30);
      chk("R7 R9 full-speed fallback", obs(), exp_vec(0, 1'b0));
    end
    cyc(20);
    chk("R10 holds while SE0", obs(), exp_vec(exp_hs ? 3 : 0, exp_hs));
    line = LJ;
    cyc(DEB + 6);
    chk("R10 idle after J", obs(), exp_vec(0, exp_hs));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0417));
    cyc(3);
    chk("R1 outputs in reset", obs(), exp_vec(0, 1'b0));
    cyc(2);
    rst = 1'b0;
    cyc(5);
    chk("R1 idle after reset", obs(), exp_vec(0, 1'b0));

    // R2: one-cycle pulses never pass the filter
    for (int i = 0; i < 60; i++) begin
      line = (i % 3 == 0) ? SE1 : SE0;
      cyc(1);
      line = LJ;
      cyc(1 + (i % 2));
    end
    chk("R2 glitch train ignored", obs(), exp_vec(0, 1'b0));
    for (int i = 0; i < 3 * RECOG; i++) begin
      line = (i % 2 == 0) ? SE0 : LJ;
      cyc(1);
    end
    line = LJ;
    cyc(8);
    chk("R2 alternating SE0 ignored", obs(), exp_vec(0, 1'b0));

    // R3: early end of SE0, count discarded
    line = SE0; cyc(RECOG - 10);
    line = SE1; cyc(4);
    line = LJ;  cyc(20);
    chk("R3 SE1 aborts", obs(), exp_vec(0, 1'b0));
    line = SE0; cyc(RECOG - 10);
    line = LJ;  cyc(DEB + 3);
    line = SE0; cyc(RECOG - 10);
    line = LJ;  cyc(20);
    chk("R3 count discarded", obs(), exp_vec(0, 1'b0));

    // directed outcomes
    bus_reset(1, 0);
    bus_reset(0, 0);
    bus_reset(2, 0);
    bus_reset(3, 0);
    bus_reset(4, 0);
    bus_reset(1, 3);

    // random mix
    for (int i = 0; i < 10; i++) begin
      if ($urandom % 2 == 1) begin
        line = SE0; cyc(RECOG - 10 - ($urandom % 10));
        line = LJ;  cyc(12);
        chk("R3 random short SE0", obs(), exp_vec(0, exp_hs));
      end
      bus_reset(int'($urandom % 5), int'($urandom % 4));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule